// File: doc/BRIEF.md
# Instruction-Addressed Register File with Writeback Select

This block holds the general registers of a small 16-bit load/store core. There are eight 16-bit entries. The block takes the raw instruction word and cuts its three register indices out of fixed bit fields, so no decoder has to sit between the instruction register and the register array. Two read ports are combinational.

The first read port always serves the middle source field. The second read port serves either the low source field or the destination field, chosen by a one-bit select. The destination form is the one used by stores and branches, which read the register they would otherwise write.

Writeback is also inside the block. A two-bit select chooses what is written:

- the memory load data,
- the ALU result, or
- the incremented program counter, used as a link address.

The chosen value is written to the destination register on the rising clock edge when the write enable is high. Entry 0 is a constant zero. The control inputs come from an external decoder.

Top module: `instr_regfile`

## Requirements
- R1: When `rst` is high at a rising edge, all registers are cleared. After `rst` falls, every read returns 0 until a write occurs. This holds even if `wr_en` was high during reset.
- R2: Register indices come only from fixed instruction bits: destination `instr[12:10]`, first source `instr[9:7]`, second source `instr[2:0]`. Bits [15:13] and [6:3] have no effect on any read or write.
- R3: `rd1_data` returns, in the same cycle and without a clock edge, the register named by `instr[9:7]`.
- R4: `rd2_data` returns the register named by `instr[2:0]` when `rd2_use_dst` is 0, and the register named by `instr[12:10]` when `rd2_use_dst` is 1.
- R5: The written value is chosen by `wb_src`:
  - 2'b00 selects `mem_rdata`,
  - 2'b01 selects `alu_result`,
  - 2'b10 selects `pc_cur + 1` modulo 2^16 (0xFFFF becomes 0x0000; 0xF00D becomes 0xF00E).
- R6: A write changes the register only at a rising edge with `wr_en` high. Before that edge the old value still reads back; one delta after it the new value appears on both read ports.
- R7: A write whose destination field is 0 changes no register, and register 0 always reads as 0.
- R8: While `wr_en` is low, no register changes, whatever `wb_src`, the data inputs and the instruction are.
- R9: The reserved code `wb_src` = 2'b11 writes the value 0 into the destination register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous clear of all registers |
| instr | input | 16 | Raw instruction word supplying the register index fields |
| rd2_use_dst | input | 1 | Second read port index: 0 = low source field, 1 = destination field |
| wr_en | input | 1 | Write enable for the destination register |
| wb_src | input | 2 | Writeback source: 00 memory, 01 ALU, 10 PC+1, 11 zero |
| mem_rdata | input | 16 | Load data from memory |
| alu_result | input | 16 | ALU result |
| pc_cur | input | 16 | Current program counter |
| rd1_data | output | 16 | Contents of the register named by the first source field |
| rd2_data | output | 16 | Contents of the register named by the second source or destination field |

## Verification
A corrupted entry, a write sent to the wrong index, or a wrong writeback choice stays hidden until that entry is read. For that reason, every write is followed by a sweep that reads all eight registers through both ports and both select settings. Any such error therefore shows at the ports within the same write step.

A write that lands early shows up before the edge in the pre-edge read. A write that lands late, or not at all, shows up right after the edge. Damage to entry 0, and writes leaking through while the enable is low, are caught by the following full sweep.

// File: rtl/irf_pkg.sv
package irf_pkg;

  // Default geometry of the register file.
  localparam int DEF_DATA_W = 16;
  localparam int DEF_NUM_REGS = 8;

  // Instruction field positions. The core's decoder relies on these,
  // so they are fixed.
  localparam int FLD_DST_LSB = 10;
  localparam int FLD_SRCA_LSB = 7;
  localparam int FLD_SRCB_LSB = 0;

  typedef enum logic [1:0] {
    WB_LOAD = 2'b00,
    WB_ALU  = 2'b01,
    WB_LINK = 2'b10,
    WB_NONE = 2'b11
  } wb_src_e;

endpackage

// File: rtl/irf_field_decode.sv
module irf_field_decode #(
  parameter int INSTR_W  = 16,
  parameter int IDX_W    = 3,
  parameter int DST_LSB  = 10,
  parameter int SRCA_LSB = 7,
  parameter int SRCB_LSB = 0
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [IDX_W-1:0]   srca_idx,
  output logic [IDX_W-1:0]   srcb_idx
);

  localparam int GAP_HI  = SRCA_LSB - 1;
  localparam int GAP_LO  = SRCB_LSB + IDX_W;
  localparam int HEAD_LO = DST_LSB + IDX_W;

  function automatic logic [IDX_W-1:0] slice_field(input logic [INSTR_W-1:0] w,
                                                   input int lsb);
    return IDX_W'(w >> lsb);
  endfunction

  assign dst_idx  = slice_field(instr, DST_LSB);
  assign srca_idx = slice_field(instr, SRCA_LSB);
  assign srcb_idx = slice_field(instr, SRCB_LSB);

  // The opcode and the gap bits carry no index information.
  logic unused_bits;
  assign unused_bits = ^{instr[INSTR_W-1:HEAD_LO], instr[GAP_HI:GAP_LO]};

endmodule

// File: rtl/irf_wb_select.sv
module irf_wb_select
  import irf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        wb_src,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_result,
  input  logic [DATA_W-1:0] pc_cur,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_reserved
);

  // Link address: the program counter plus one, wrapping at the word width.
  function automatic logic [DATA_W-1:0] link_of(input logic [DATA_W-1:0] pc);
    return pc + DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] choose(input logic [1:0] sel,
                                               input logic [DATA_W-1:0] ld,
                                               input logic [DATA_W-1:0] al,
                                               input logic [DATA_W-1:0] pc);
    case (wb_src_e'(sel))
      WB_LOAD: return ld;
      WB_ALU:  return al;
      WB_LINK: return link_of(pc);
      default: return '0;
    endcase
  endfunction

  assign wb_data     = choose(wb_src, mem_rdata, alu_result, pc_cur);
  assign wb_reserved = (wb_src_e'(wb_src) == WB_NONE);

endmodule

// File: rtl/irf_storage.sv
module irf_storage #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdata
);

  // Entry 0 has no storage; only entries 1..NUM_REGS-1 hold state.
  logic [NUM_REGS-1:1][DATA_W-1:0] bank_q;
  logic [NUM_REGS-1:1]             wr_hit;

  function automatic logic [DATA_W-1:0] read_entry(
      input logic [NUM_REGS-1:1][DATA_W-1:0] bank,
      input logic [IDX_W-1:0]                idx);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int k = 1; k < NUM_REGS; k++) begin
      if (idx == IDX_W'(k)) v = bank[k];
    end
    return v;
  endfunction

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_entry
    assign wr_hit[g] = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)            bank_q[g] <= '0;
      else if (wr_hit[g]) bank_q[g] <= wdata;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
    always_comb rdata[p] = read_entry(bank_q, raddr[p]);
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bank_q));

endmodule

// File: rtl/instr_regfile.sv
module instr_regfile
  import irf_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NUM_REGS = DEF_NUM_REGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instr,
  input  logic              rd2_use_dst,
  input  logic              wr_en,
  input  logic [1:0]        wb_src,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_result,
  input  logic [DATA_W-1:0] pc_cur,
  output logic [DATA_W-1:0] rd1_data,
  output logic [DATA_W-1:0] rd2_data
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0]        dst_idx, srca_idx, srcb_idx, rd2_idx;
  logic [DATA_W-1:0]       wb_data;
  logic                    wb_reserved;
  logic                    wr_commit;
  logic [1:0][IDX_W-1:0]   rd_addr;
  logic [1:0][DATA_W-1:0]  rd_data;

  irf_field_decode #(
    .INSTR_W(DATA_W), .IDX_W(IDX_W),
    .DST_LSB(FLD_DST_LSB), .SRCA_LSB(FLD_SRCA_LSB), .SRCB_LSB(FLD_SRCB_LSB)
  ) u_decode (
    .instr(instr), .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx)
  );

  irf_wb_select #(.DATA_W(DATA_W)) u_wb (
    .wb_src(wb_src), .mem_rdata(mem_rdata), .alu_result(alu_result),
    .pc_cur(pc_cur), .wb_data(wb_data), .wb_reserved(wb_reserved)
  );

  assign rd2_idx    = rd2_use_dst ? dst_idx : srcb_idx;
  assign rd_addr[0] = srca_idx;
  assign rd_addr[1] = rd2_idx;
  assign wr_commit  = wr_en && (dst_idx != '0);

  irf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_RD(2)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(dst_idx), .wdata(wb_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign rd1_data = rd_data[0];
  assign rd2_data = rd_data[1];

  // R1
  clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd1_data == '0 && rd2_data == '0));

  // R4
  port2_src_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd2_use_dst && srcb_idx == srca_idx) |-> rd2_data == rd1_data);

  // R4
  port2_dst_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rd2_use_dst && dst_idx == srca_idx) |-> rd2_data == rd1_data);

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> (srca_idx != $past(dst_idx)) || (rd1_data == $past(wb_data)));

  // R7
  zero_dst_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dst_idx == '0) ##1 $stable(instr) |-> $stable(rd1_data));

  // R9
  reserved_src_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wb_reserved) |=> (srca_idx != $past(dst_idx)) || (rd1_data == '0));

endmodule

// File: tb/instr_regfile_bench.sv
`timescale 1ns / 1ps
module instr_regfile_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr;
  logic        rd2_use_dst;
  logic        wr_en;
  logic [1:0]  wb_src;
  logic [15:0] mem_rdata, alu_result, pc_cur;
  logic [15:0] rd1_data, rd2_data;

  logic [15:0] model [8];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  instr_regfile u_instr_regfile (
    .clk(clk), .rst(rst), .instr(instr), .rd2_use_dst(rd2_use_dst),
    .wr_en(wr_en), .wb_src(wb_src), .mem_rdata(mem_rdata),
    .alu_result(alu_result), .pc_cur(pc_cur),
    .rd1_data(rd1_data), .rd2_data(rd2_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Fields: dst [12:10], srcA [9:7], srcB [2:0]; junk in [15:13] and [6:3] (R2).
  function automatic logic [15:0] mk_instr(input int d, input int a, input int b, input int junk);
    return {3'(junk), 3'(d), 3'(a), 4'(junk >> 3), 3'(b)};
  endfunction

  function automatic logic [15:0] expect_wb(input int sel, input logic [15:0] m,
                                            input logic [15:0] a, input logic [15:0] p);
    logic [16:0] wide;
    wide = {1'b0, p} + 17'd1;
    if (sel == 0) return m;
    if (sel == 1) return a;
    if (sel == 2) return wide[15:0];
    return 16'h0000;
  endfunction

  // Sweep every register through both ports and both select settings.
  task automatic sweep(input string tag);
    wr_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      int bi, di;
      bi = (k + 3) % 8;
      di = (k + 5) % 8;
      instr = mk_instr(di, k, bi, k * 9 + 17);
      rd2_use_dst = 1'b0;
      #1;
      check({tag, " R3 port1"}, rd1_data, model[k]);
      check({tag, " R4 port2 srcB"}, rd2_data, model[bi]);
      rd2_use_dst = 1'b1;
      #1;
      check({tag, " R4 port2 dst"}, rd2_data, model[di]);
      check({tag, " R2 junk-bit port1"}, rd1_data, model[k]);
    end
  endtask

  task automatic write_step(input int sel, input int d, input int we, input int n);
    logic [15:0] m, a, p, exp;
    string tag;
    m = 16'h3C00 + 16'(n * 16'h0107);
    a = 16'h8001 ^ 16'(n * 16'h0B0B);
    if (n % 5 == 0)      p = 16'hFFFF;
    else if (n % 5 == 1) p = 16'hF00D;
    else                 p = 16'h0040 + 16'(n * 3);
    @(negedge clk);
    instr = mk_instr(d, d, d, n * 5 + 1);
    rd2_use_dst = 1'b1;
    wb_src = 2'(sel);
    mem_rdata = m;
    alu_result = a;
    pc_cur = p;
    wr_en = we[0];
    #1;
    check("R6 before edge", rd1_data, model[d]);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    exp = expect_wb(sel, m, a, p);
    if (we != 0 && d != 0) model[d] = exp;
    if (we == 0)        tag = "R8 disabled";
    else if (d == 0)    tag = "R7 zero dst";
    else if (sel == 3)  tag = "R9 reserved src";
    else                tag = "R5 source";
    check({tag, " R6 after edge port1"}, rd1_data, model[d]);
    check({tag, " R6 after edge port2"}, rd2_data, model[d]);
    sweep(tag);
  endtask

  initial begin
    rst = 1'b1;
    wr_en = 1'b1;
    instr = mk_instr(4, 4, 4, 0);
    rd2_use_dst = 1'b0;
    wb_src = 2'b01;
    mem_rdata = 16'hDEAD;
    alu_result = 16'hBEEF;
    pc_cur = 16'h1234;
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    wr_en = 1'b0;
    rst = 1'b0;
    sweep("R1 initial");
    begin
      int n;
      n = 0;
      for (int sel = 0; sel < 4; sel++)
        for (int d = 0; d < 8; d++)
          for (int we = 1; we >= 0; we--) begin
            write_step(sel, d, we, n);
            n++;
          end
    end
    // Reset with a write pending: reset wins and everything clears.
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b1;
    wb_src = 2'b01;
    alu_result = 16'h5A5A;
    instr = mk_instr(3, 3, 3, 0);
    @(negedge clk);
    wr_en = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    sweep("R1 mid-run reset");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule